// File: doc/BRIEF.md
# Timed Register-Write Packet Player

The block replays a recorded sequence of register writes at the times stored in a byte stream. The stream is a series of packets. Each packet opens with a two-byte wait, counted in ticks of a clock-enable input. Next come zero or more pairs of register number and value, and the packet ends with a marker byte. After it loads the wait, the block holds off until that many ticks have passed. It then sends every pair to a downstream write port through a valid/ready handshake and returns to read the next wait.

A second marker value ends the whole sequence. The block then writes zero to every register, highest number first, and stops until the next reset. A write to one of the volume registers also sets the duty of an LED PWM output. The duty comes from a logarithmic 16-entry curve indexed by the low nibble of the written value. The byte source may stall at any point without losing parser state.

Top module: `pkt_player`

## Requirements
- R1: The first two bytes of a packet form an unsigned 16-bit wait, with the most significant byte received first.
- R2: After the low wait byte is accepted, the tick count restarts from zero. No register-number byte of that packet is accepted before the count has reached the wait value, and `in_ready` rises no later than one clock after the count reaches it.
- R3: Each pair is presented on `wr_addr`/`wr_data` with `wr_valid` high, in stream order. The pair is held steady until a clock edge with `wr_ready` high completes the transfer.
- R4: A register-number byte of 0xFF ends the packet, and the next byte accepted is a new high wait byte. A packet with no pairs is legal and produces no write.
- R5: A register-number byte of 0xFE writes value 0 to registers NUM_REGS-1 down to 0, in that order. Afterwards `halted` is 1, `in_ready` and `wr_valid` stay 0, and nothing changes until reset.
- R6: A completed write to register VOL_BASE+i sets the duty of LED i to the curve entry selected by value bits [3:0]. The curve is 0,1,2,3,5,7,10,15,22,31,44,63,90,127,180,255 for entries 0 to 15. Writes to any other register leave every duty unchanged.
- R7: A shared 8-bit PWM counter starts at 0 on reset and advances by one on every clock. `led[i]` is high exactly while the counter is below duty i, so a duty of 0 keeps the LED low.
- R8: Input bytes transfer only on clock edges where `in_valid` and `in_ready` are both high. An idle input, or a downstream stall, leaves the parse position and all held data intact.
- R9: During and just after reset, `in_ready` is 1, `wr_valid` and `halted` are 0, every duty is 0 and every LED is low.
- R10: The wait count advances only on clock edges where `tick_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Clock enable for the wait counter |
| in_valid | input | 1 | Input byte is valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block accepts an input byte this cycle |
| wr_valid | output | 1 | Register write is pending |
| wr_ready | input | 1 | Downstream takes the pending write |
| wr_addr | output | 8 | Register number of the write |
| wr_data | output | 8 | Value of the write |
| led | output | NUM_LEDS | LED PWM outputs |
| halted | output | 1 | Sequence has ended, block is idle until reset |

## Verification
The bench builds the block with its defaults: sixteen registers, volume registers 8 to 10, and three LEDs. With these values the whole end-of-sequence clear stays short, and it passes over every volume register, so the clear visibly drives all three duties back to zero. A 16-bit wait of 0x0102, run with a tick every third clock, separates correct byte order from swapped order. It also separates ticks from plain clocks, and it still finishes in under a thousand cycles.

// File: rtl/pkt_player_pkg.sv
package pkt_player_pkg;

   localparam int DLY_W = 16;
   localparam int BYTE_W = 8;
   localparam int PWM_W = 8;

   localparam logic [BYTE_W-1:0] MARK_PKT_END  = 8'hFF;
   localparam logic [BYTE_W-1:0] MARK_SONG_END = 8'hFE;

   typedef enum logic [2:0] {
      PS_DLY_HI,
      PS_DLY_LO,
      PS_WAIT,
      PS_REG,
      PS_VAL,
      PS_EMIT,
      PS_WIPE,
      PS_STOP
   } parse_st_e;

   // Logarithmic brightness curve, one entry per volume level
   function automatic logic [PWM_W-1:0] vol_to_duty(input logic [3:0] lvl);
      logic [PWM_W-1:0] d;
      case (lvl)
         4'd0:  d = 8'd0;
         4'd1:  d = 8'd1;
         4'd2:  d = 8'd2;
         4'd3:  d = 8'd3;
         4'd4:  d = 8'd5;
         4'd5:  d = 8'd7;
         4'd6:  d = 8'd10;
         4'd7:  d = 8'd15;
         4'd8:  d = 8'd22;
         4'd9:  d = 8'd31;
         4'd10: d = 8'd44;
         4'd11: d = 8'd63;
         4'd12: d = 8'd90;
         4'd13: d = 8'd127;
         4'd14: d = 8'd180;
         default: d = 8'd255;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/pkt_delay_timer.sv
module pkt_delay_timer
   import pkt_player_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DLY_W-1:0] load_val,
   input  logic             tick_en,
   output logic             done
);

   localparam logic [DLY_W-1:0] CNT_MAX = '1;

   logic [DLY_W-1:0] cnt_q;
   logic [DLY_W-1:0] target_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         target_q <= '0;
      end else if (load) begin
         cnt_q    <= '0;
         target_q <= load_val;
      end else if (tick_en && (cnt_q != CNT_MAX)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done = (cnt_q >= target_q);

endmodule

// File: rtl/pkt_parser.sv
module pkt_parser
   import pkt_player_pkg::*;
#(
   parameter int NUM_REGS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_data,
   output logic              in_ready,
   output logic              tm_load,
   output logic [DLY_W-1:0]  tm_value,
   input  logic              tm_done,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [BYTE_W-1:0] wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic              clearing,
   output logic              halted
);

   localparam logic [BYTE_W-1:0] LAST_REG = BYTE_W'(NUM_REGS - 1);

   parse_st_e         st_q;
   logic [BYTE_W-1:0] dly_hi_q;
   logic [BYTE_W-1:0] reg_q;
   logic [BYTE_W-1:0] val_q;
   logic [BYTE_W-1:0] wipe_idx_q;
   logic              take;

   always_comb begin
      in_ready = (st_q == PS_DLY_HI) || (st_q == PS_DLY_LO) ||
                 (st_q == PS_REG)    || (st_q == PS_VAL);
   end

   assign take     = in_valid && in_ready;
   assign tm_load  = take && (st_q == PS_DLY_LO);
   assign tm_value = {dly_hi_q, in_data};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= PS_DLY_HI;
         dly_hi_q   <= '0;
         reg_q      <= '0;
         val_q      <= '0;
         wipe_idx_q <= '0;
      end else begin
         case (st_q)
            PS_DLY_HI: if (take) begin
               dly_hi_q <= in_data;
               st_q     <= PS_DLY_LO;
            end
            PS_DLY_LO: if (take) st_q <= PS_WAIT;
            PS_WAIT:   if (tm_done) st_q <= PS_REG;
            PS_REG: if (take) begin
               if (in_data == MARK_PKT_END) begin
                  st_q <= PS_DLY_HI;
               end else if (in_data == MARK_SONG_END) begin
                  wipe_idx_q <= LAST_REG;
                  st_q       <= PS_WIPE;
               end else begin
                  reg_q <= in_data;
                  st_q  <= PS_VAL;
               end
            end
            PS_VAL: if (take) begin
               val_q <= in_data;
               st_q  <= PS_EMIT;
            end
            PS_EMIT: if (wr_ready) st_q <= PS_REG;
            PS_WIPE: if (wr_ready) begin
               if (wipe_idx_q == '0) st_q <= PS_STOP;
               else wipe_idx_q <= wipe_idx_q - 1'b1;
            end
            default: st_q <= PS_STOP;
         endcase
      end
   end

   always_comb begin
      clearing = (st_q == PS_WIPE);
      halted   = (st_q == PS_STOP);
      wr_valid = (st_q == PS_EMIT) || clearing;
      wr_addr  = clearing ? wipe_idx_q : reg_q;
      wr_data  = clearing ? '0 : val_q;
   end

endmodule

// File: rtl/pkt_led_pwm.sv
module pkt_led_pwm
   import pkt_player_pkg::*;
#(
   parameter int NUM_LEDS = 3,
   parameter int VOL_BASE = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      upd_en,
   input  logic [BYTE_W-1:0]         upd_addr,
   input  logic [3:0]                upd_lvl,
   output logic [NUM_LEDS-1:0]       led,
   output logic [NUM_LEDS*PWM_W-1:0] duty_flat
);

   logic [PWM_W-1:0] ramp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ramp_q <= '0;
      else        ramp_q <= ramp_q + 1'b1;
   end

   for (genvar i = 0; i < NUM_LEDS; i++) begin : g_chan
      localparam logic [BYTE_W-1:0] MY_REG = BYTE_W'(VOL_BASE + i);
      logic [PWM_W-1:0] duty_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         duty_q <= '0;
         else if (upd_en && upd_addr == MY_REG) duty_q <= vol_to_duty(upd_lvl);
      end

      assign led[i] = (ramp_q < duty_q);
      assign duty_flat[i*PWM_W +: PWM_W] = duty_q;
   end

endmodule

// File: rtl/pkt_player.sv
module pkt_player
   import pkt_player_pkg::*;
#(
   parameter int NUM_REGS = 16,
   parameter int VOL_BASE = 8,
   parameter int NUM_LEDS = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_en,
   input  logic                in_valid,
   input  logic [7:0]          in_data,
   output logic                in_ready,
   output logic                wr_valid,
   input  logic                wr_ready,
   output logic [7:0]          wr_addr,
   output logic [7:0]          wr_data,
   output logic [NUM_LEDS-1:0] led,
   output logic                halted
);

   if (NUM_REGS < 2 || NUM_REGS > 254) begin : g_bad_regs
      $error("NUM_REGS must lie in 2..254");
   end
   if (NUM_LEDS < 1) begin : g_bad_leds
      $error("NUM_LEDS must be at least 1");
   end
   if (VOL_BASE < 0 || VOL_BASE + NUM_LEDS > NUM_REGS) begin : g_bad_vol
      $error("volume registers must lie inside the cleared range");
   end

   logic                      tm_load;
   logic [DLY_W-1:0]          tm_value;
   logic                      tm_done;
   logic                      clearing;
   logic [NUM_LEDS*PWM_W-1:0] duty_flat;

   pkt_delay_timer u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tm_load),
      .load_val (tm_value),
      .tick_en  (tick_en),
      .done     (tm_done)
   );

   pkt_parser #(.NUM_REGS(NUM_REGS)) u_parser (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_ready (in_ready),
      .tm_load  (tm_load),
      .tm_value (tm_value),
      .tm_done  (tm_done),
      .wr_valid (wr_valid),
      .wr_ready (wr_ready),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .clearing (clearing),
      .halted   (halted)
   );

   pkt_led_pwm #(.NUM_LEDS(NUM_LEDS), .VOL_BASE(VOL_BASE)) u_leds (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_en    (wr_valid && wr_ready),
      .upd_addr  (wr_addr),
      .upd_lvl   (wr_data[3:0]),
      .led       (led),
      .duty_flat (duty_flat)
   );

endmodule

// File: rtl/pkt_player_chk.sv
module pkt_player_chk #(
   parameter int NUM_LEDS = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_ready,
   input logic                  wr_valid,
   input logic                  wr_ready,
   input logic [7:0]            wr_addr,
   input logic [7:0]            wr_data,
   input logic                  clearing,
   input logic                  halted,
   input logic [NUM_LEDS-1:0]   led,
   input logic [NUM_LEDS*8-1:0] duty_flat
);

   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R3

   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted); // R5

   AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (!in_ready && !wr_valid)); // R5

   AST_HALT_AFTER_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted) |-> ($past(clearing) && $past(wr_ready))); // R5

   AST_NO_TAKE_WHILE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> !in_ready); // R8

   AST_DUTY_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_valid && wr_ready) |=> $stable(duty_flat)); // R6

   for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
      AST_LED_DARK: assert property (@(posedge clk) disable iff (!rst_n)
         (duty_flat[i*8 +: 8] == 8'd0) |-> !led[i]); // R7
   end

endmodule

bind pkt_player pkt_player_chk #(.NUM_LEDS(NUM_LEDS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_ready  (in_ready),
   .wr_valid  (wr_valid),
   .wr_ready  (wr_ready),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .clearing  (clearing),
   .halted    (halted),
   .led       (led),
   .duty_flat (duty_flat)
);

// File: tb/pkt_player_tb_top.sv
`timescale 1ns/100ps
module pkt_player_tb_top;

   localparam int NREG = 16;
   localparam int VBASE = 8;
   localparam int NLED = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            tick_en = 1'b1;
   logic            in_valid = 1'b0;
   logic [7:0]      in_data = 8'h00;
   logic            in_ready;
   logic            wr_valid;
   logic            wr_ready = 1'b1;
   logic [7:0]      wr_addr;
   logic [7:0]      wr_data;
   logic [NLED-1:0] led;
   logic            halted;

   always #2.5 clk = ~clk;

   pkt_player #(.NUM_REGS(NREG), .VOL_BASE(VBASE), .NUM_LEDS(NLED)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
      .wr_data(wr_data), .led(led), .halted(halted)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int curve(input int lvl);
      int t[16] = '{0, 1, 2, 3, 5, 7, 10, 15, 22, 31, 44, 63, 90, 127, 180, 255};
      return t[lvl & 15];
   endfunction

   // ---------------- reference model state ----------------
   typedef enum int {M_HI, M_LO, M_REG, M_VAL, M_DONE} mrole_e;
   mrole_e   role = M_HI;
   int       dly_hi = 0, dly = 0, tc = 0;
   bit       waiting = 0, skip_tick = 0, tick_prev = 0, due_prev = 0;
   int       cur_reg = 0;
   int       exp_q[$];
   int       duty_exp[NLED];
   int       ramp = 0;
   bit       hs_pend = 0;
   int       hs_addr = 0, hs_data = 0;
   int       tick_mode = 0, rdy_mode = 0, phase = 0;

   // stimulus patterns for tick_en and wr_ready
   always @(negedge clk) begin
      phase = phase + 1;
      tick_en  = (tick_mode == 0) ? 1'b1 : (phase % 3 == 0);
      wr_ready = (rdy_mode == 0) ? 1'b1 : (phase % 3 == 1);
   end

   // model of state that changes at the clock edge
   always @(posedge clk) begin
      if (!rst_n) begin
         ramp = 0;
      end else begin
         ramp = (ramp + 1) % 256;
         if (hs_pend) begin
            for (int i = 0; i < NLED; i++)
               if (hs_addr == VBASE + i) duty_exp[i] = curve(hs_data);
            hs_pend = 0;
         end
      end
   end

   // per-cycle comparison, sampled after the falling edge
   always begin
      @(negedge clk);
      #1;
      if (!rst_n) begin
         role = M_HI; waiting = 0; skip_tick = 0; due_prev = 0; hs_pend = 0;
         exp_q.delete();
         for (int i = 0; i < NLED; i++) duty_exp[i] = 0;
      end else begin
         if (waiting && tick_prev && !skip_tick) tc++;
         skip_tick = 0;
         // R7 / R6: LED outputs follow the modelled duty and ramp
         for (int i = 0; i < NLED; i++)
            chk(led[i] == (ramp < duty_exp[i]), "R7", $sformatf("led%0d", i),
                led[i], (ramp < duty_exp[i]));
         // R2 / R1 / R10: wait window
         if (due_prev && waiting)
            chk(in_ready, "R2", "late after wait elapsed", in_ready, 1);
         if (waiting && in_ready) begin
            chk(tc >= dly, "R2", "register byte before wait (R1 R10)", tc, dly);
            waiting = 0;
         end
         due_prev = waiting && (tc >= dly);
         // input byte transfer model
         if (in_valid && in_ready) begin
            case (role)
               M_HI: begin dly_hi = in_data; role = M_LO; end
               M_LO: begin
                  dly = dly_hi * 256 + in_data;
                  waiting = 1; tc = 0; skip_tick = 1; role = M_REG;
               end
               M_REG: begin
                  if (in_data == 8'hFF) role = M_HI;
                  else if (in_data == 8'hFE) begin
                     for (int r = NREG - 1; r >= 0; r--) exp_q.push_back(r * 256);
                     role = M_DONE;
                  end else begin
                     cur_reg = in_data; role = M_VAL;
                  end
               end
               M_VAL: begin exp_q.push_back(cur_reg * 256 + in_data); role = M_REG; end
               default: chk(0, "R5", "byte taken after end", in_data, -1);
            endcase
         end
         // write port
         if (wr_valid && wr_ready) begin
            if (exp_q.size() == 0) begin
               chk(0, "R3", "unexpected write", wr_addr * 256 + wr_data, -1);
            end else begin
               int e;
               e = exp_q.pop_front();
               chk(wr_addr * 256 + wr_data == e, "R3", "write addr*256+data",
                   wr_addr * 256 + wr_data, e);
            end
            hs_pend = 1; hs_addr = wr_addr; hs_data = wr_data;
         end
         tick_prev = tick_en;
      end
   end

   task automatic send_byte(input logic [7:0] b, input int gap);
      bit ok;
      repeat (gap) @(negedge clk);
      in_valid = 1'b1;
      in_data  = b;
      do begin
         ok = in_ready;
         @(negedge clk);
      end while (!ok);
      in_valid = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic finish_test();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      finish_test();
   end

   task automatic reset_and_check();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      // R9: state while reset is held
      chk(in_ready == 1, "R9", "in_ready in reset", in_ready, 1);
      chk(wr_valid == 0, "R9", "wr_valid in reset", wr_valid, 0);
      chk(halted == 0, "R9", "halted in reset", halted, 0);
      chk(led == '0, "R9", "led in reset", led, 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      reset_and_check();
      repeat (2) @(negedge clk);

      // R1 R2 R6: short wait, volume write to LED 0, plain register write
      send_byte(8'h00, 0); send_byte(8'h05, 0);
      send_byte(8'h08, 0); send_byte(8'h0A, 0);
      send_byte(8'h07, 0); send_byte(8'h33, 0);
      send_byte(8'hFF, 0);
      drain();

      // R4: filler packet, zero wait, no pairs
      send_byte(8'h00, 0); send_byte(8'h00, 0); send_byte(8'hFF, 0);
      drain();

      // R1 R10 R3: wait 0x0102 ticks at one tick per three clocks, write stalls
      tick_mode = 1; rdy_mode = 1;
      send_byte(8'h01, 0); send_byte(8'h02, 0);
      send_byte(8'h09, 0); send_byte(8'hF3, 0);
      send_byte(8'h0A, 0); send_byte(8'h0F, 0);
      send_byte(8'h0B, 0); send_byte(8'h55, 0);
      send_byte(8'hFF, 0);
      drain();
      repeat (300) @(negedge clk);

      // R8: gaps between bytes, LED 0 back to dark
      tick_mode = 0; rdy_mode = 0;
      send_byte(8'h00, 3); send_byte(8'h03, 4);
      send_byte(8'h08, 2); send_byte(8'h00, 5);
      send_byte(8'hFF, 3);
      drain();

      // R5: end of sequence with a wipe under backpressure
      rdy_mode = 1;
      send_byte(8'h00, 0); send_byte(8'h02, 0);
      send_byte(8'h09, 0); send_byte(8'h07, 0);
      send_byte(8'hFE, 0);
      drain();
      #1;
      chk(halted == 1, "R5", "halted after wipe", halted, 1);
      in_valid = 1'b1; in_data = 8'h12;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk); #1;
         chk(in_ready == 0 && wr_valid == 0, "R5", "idle after end",
             {in_ready, wr_valid}, 0);
      end
      in_valid = 1'b0;
      rdy_mode = 0;
      repeat (300) @(negedge clk);

      // R9: second reset clears the halt, then a short sequence again
      reset_and_check();
      #1;
      chk(halted == 0, "R9", "halted after reset", halted, 0);
      send_byte(8'h00, 0); send_byte(8'h01, 0);
      send_byte(8'h0A, 0); send_byte(8'h0D, 0);
      send_byte(8'hFF, 0);
      drain();
      repeat (300) @(negedge clk);
      finish_test();
   end

endmodule